// File: doc/BRIEF.md
# Multiply/Divide Unit with Result Registers

This unit performs 32-bit signed and unsigned multiplication and division and keeps the results in two dedicated result registers: HI and LO. A multiply leaves the 64-bit product split across HI and LO. A divide leaves the quotient in LO and the remainder in HI. Two move operations load HI or LO directly from the first operand. Both registers are always visible on the output ports, so reading them needs no operation.

A request is an operation code and two operands, qualified by a one-cycle start strobe. Multiplication uses a single-cycle array product followed by one write cycle. Division uses an iterative restoring divider that produces one quotient bit per cycle, plus one cycle to correct the signs. While either operation is in flight, `busy_o` is high and any new start is ignored. `done_o` pulses for one cycle when a result lands in HI/LO.

Division by zero is defined: it clears both HI and LO. The one signed overflow case, the most negative dividend divided by minus one, wraps without any trap.

Top module: `muldiv_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `hi_o`, `lo_o`, `busy_o` and `done_o` are all zero.
- R2: `op_i` encodes 0 = signed multiply, 1 = unsigned multiply, 2 = signed divide, 3 = unsigned divide, 4 = load HI from `a_i`, 5 = load LO from `a_i`. Codes 6 and 7 change neither register and give no `done_o`.
- R3: A multiply writes bits 63..32 of the 64-bit product to HI and bits 31..0 to LO. The signed form reads the operands as two's complement; the unsigned form reads them as 0 to 2^32-1.
- R4: For a multiply, `busy_o` is high for exactly one cycle after the start edge. On the following edge the product is written and `done_o` rises.
- R5: An unsigned divide writes the quotient to LO and the remainder to HI.
- R6: A signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R8: A divide by zero, signed or unsigned, sets both HI and LO to 0.
- R9: For a divide, `busy_o` stays high for 33 cycles after the start edge, and the result and `done_o` appear on the edge that lowers `busy_o`.
- R10: A load of HI or LO takes effect on the start edge, with `done_o` the next cycle and `busy_o` never raised. The other register is unchanged.
- R11: A start strobe while `busy_o` is high is ignored. It does not alter HI, LO, the pending result or its timing.
- R12: `done_o` is a single-cycle pulse. It is never high while `busy_o` is high, and it accompanies every fall of `busy_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted when not busy |
| op_i | input | 3 | Operation code (see R2) |
| a_i | input | 32 | First operand: multiplicand, dividend or move source |
| b_i | input | 32 | Second operand: multiplier or divisor |
| busy_o | output | 1 | Multiply or divide in progress |
| done_o | output | 1 | One-cycle pulse when HI/LO have been written |
| hi_o | output | 32 | Current HI register |
| lo_o | output | 32 | Current LO register |

## Verification
The hardest situation to create from the ports is a request that arrives in the middle of a divide. Nothing at the interface stops a caller from strobing start while busy, so the bench does exactly that. Five cycles into an unsigned divide it issues a load-HI with a marker value, then checks that the divide still finishes after the same 33 busy cycles with its own remainder in HI. The signed corner cases are driven directly as operand pairs: each sign combination of dividend and divisor, the wrapping minimum-by-minus-one case, and zero divisors. Each is compared against 64-bit arithmetic computed in the bench.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_MULS  = 3'd0,
    OP_MULU  = 3'd1,
    OP_DIVS  = 3'd2,
    OP_DIVU  = 3'd3,
    OP_SETHI = 3'd4,
    OP_SETLO = 3'd5
  } md_op_e;

  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_RUN  = 2'd1,
    DV_FIN  = 2'd2
  } dv_state_e;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int W = 32
) (
  input  logic           sgn_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic [2*W-1:0] xa, xb;

  // Sign- or zero-extension to the product width; low 2W bits are exact.
  always_comb begin
    xa     = {{W{sgn_i & a_i[W-1]}}, a_i};
    xb     = {{W{sgn_i & b_i[W-1]}}, b_i};
    prod_o = xa * xb;
  end
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  dv_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [W-1:0]   rem_q, rem_d;
  logic [W-1:0]   quo_q, quo_d;
  logic [W-1:0]   dvs_q, dvs_d;
  logic           negq_q, negq_d, negr_q, negr_d, zero_q, zero_d;
  logic [W:0]     shifted, trial;
  logic           en;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    st_d    = st_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    zero_d  = zero_q;
    unique case (st_q)
      DV_IDLE: if (start_i) begin
        quo_d  = (sgn_i & a_i[W-1]) ? -a_i : a_i;
        dvs_d  = (sgn_i & b_i[W-1]) ? -b_i : b_i;
        rem_d  = '0;
        cnt_d  = CW'(W);
        negq_d = sgn_i & (a_i[W-1] ^ b_i[W-1]);
        negr_d = sgn_i & a_i[W-1];
        zero_d = (b_i == '0);
        st_d   = DV_RUN;
      end
      DV_RUN: begin
        if (!trial[W]) begin
          rem_d = trial[W-1:0];
          quo_d = {quo_q[W-2:0], 1'b1};
        end else begin
          rem_d = shifted[W-1:0];
          quo_d = {quo_q[W-2:0], 1'b0};
        end
        cnt_d = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) st_d = DV_FIN;
      end
      default: st_d = DV_IDLE;
    endcase
  end

  assign en = start_i | (st_q != DV_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DV_IDLE;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      zero_q <= 1'b0;
    end else if (en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      negq_q <= negq_d;
      negr_q <= negr_d;
      zero_q <= zero_d;
    end
  end

  always_comb begin
    valid_o = (st_q == DV_FIN);
    quot_o  = zero_q ? '0 : (negq_q ? -quo_q : quo_q);
    rem_o   = zero_q ? '0 : (negr_q ? -rem_q : rem_q);
  end

  // R9: the step counter is never zero while iterating
  a_r9_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DV_RUN) |-> (cnt_q != '0));
  // R9: the sign-fix cycle is always preceded by an iteration cycle
  a_r9_fin_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DV_FIN) |-> ($past(st_q) == DV_RUN));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o
);
  localparam int PW = 2 * DATA_W;

  logic              accept, is_mul, is_div, is_sethi, is_setlo, sgn;
  logic              busy_q, busy_d, done_q, done_d;
  logic              mpend_q, mpend_d;
  logic              msgn_q, msgn_d;
  logic [DATA_W-1:0] ma_q, ma_d, mb_q, mb_d;
  logic [DATA_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [PW-1:0]     prod;
  logic              dv_valid;
  logic [DATA_W-1:0] dv_quot, dv_rem;
  logic              finish;

  always_comb begin
    is_mul   = 1'b0;
    is_div   = 1'b0;
    is_sethi = 1'b0;
    is_setlo = 1'b0;
    sgn      = 1'b0;
    case (op_i)
      OP_MULS:  begin is_mul = 1'b1; sgn = 1'b1; end
      OP_MULU:  is_mul = 1'b1;
      OP_DIVS:  begin is_div = 1'b1; sgn = 1'b1; end
      OP_DIVU:  is_div = 1'b1;
      OP_SETHI: is_sethi = 1'b1;
      OP_SETLO: is_setlo = 1'b1;
      default:  ;
    endcase
  end

  assign accept = start_i & ~busy_q;

  muldiv_mul #(.W(DATA_W)) u_mul (
    .sgn_i  (msgn_q),
    .a_i    (ma_q),
    .b_i    (mb_q),
    .prod_o (prod)
  );

  muldiv_div #(.W(DATA_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept & is_div),
    .sgn_i   (sgn),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (dv_valid),
    .quot_o  (dv_quot),
    .rem_o   (dv_rem)
  );

  assign finish = mpend_q | dv_valid;

  always_comb begin
    hi_d    = hi_q;
    lo_d    = lo_q;
    ma_d    = ma_q;
    mb_d    = mb_q;
    msgn_d  = msgn_q;
    mpend_d = accept & is_mul;
    busy_d  = (busy_q & ~finish) | (accept & (is_mul | is_div));
    done_d  = finish | (accept & (is_sethi | is_setlo));
    if (accept & is_mul) begin
      ma_d   = a_i;
      mb_d   = b_i;
      msgn_d = sgn;
    end
    if (mpend_q) begin
      hi_d = prod[PW-1:DATA_W];
      lo_d = prod[DATA_W-1:0];
    end else if (dv_valid) begin
      hi_d = dv_rem;
      lo_d = dv_quot;
    end else if (accept & is_sethi) begin
      hi_d = a_i;
    end else if (accept & is_setlo) begin
      lo_d = a_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mpend_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      mpend_q <= mpend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma_q   <= '0;
      mb_q   <= '0;
      msgn_q <= 1'b0;
    end else if (accept & is_mul) begin
      ma_q   <= ma_d;
      mb_q   <= mb_d;
      msgn_q <= msgn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (finish | accept) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  // R12: no completion pulse while an operation is still running
  a_r12_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);
  // R12: every end of a busy period carries a done pulse
  a_r12_done_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R11: results stay put while busy unless this is the completing write
  a_r11_hilo_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(hi_o) && $stable(lo_o)) || done_o);
  // R4: a multiply finishes one cycle after it is accepted
  a_r4_mul_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mpend_q |=> done_o && !busy_o);
endmodule

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  op_i;
  logic [31:0] a_i, b_i;
  logic        busy_o, done_o;
  logic [31:0] hi_o, lo_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Issue one request, wait for done; lat = negedges until done, nbusy = busy samples
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        output int lat, output int nbusy);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1; nbusy = 0;
    while (!done_o && lat < 100) begin
      if (busy_o) nbusy++;
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic [63:0] exp_mul(input logic sgn, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    sa = sgn ? longint'($signed(a)) : longint'({32'b0, a});
    sb = sgn ? longint'($signed(b)) : longint'({32'b0, b});
    return 64'(sa * sb);
  endfunction

  task automatic t_mul(input logic sgn, input logic [31:0] a, input logic [31:0] b);
    int lat, nb;
    logic [63:0] e;
    e = exp_mul(sgn, a, b);
    run_op(sgn ? 3'd0 : 3'd1, a, b, lat, nb);
    chk("R3", "mul HI", hi_o, e[63:32]);
    chk("R3", "mul LO", lo_o, e[31:0]);
    chk("R4", "mul latency", 32'(lat), 32'd2);
    chk("R4", "mul busy cycles", 32'(nb), 32'd1);
    @(negedge clk);
    chk("R12", "done single pulse", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_div(input logic sgn, input logic [31:0] a, input logic [31:0] b, input string req);
    int lat, nb;
    logic [31:0] eq, er;
    longint sa, sb;
    if (b == 0) begin
      eq = 0; er = 0;
    end else begin
      sa = sgn ? longint'($signed(a)) : longint'({32'b0, a});
      sb = sgn ? longint'($signed(b)) : longint'({32'b0, b});
      eq = 32'(sa / sb);
      er = 32'(sa % sb);
    end
    run_op(sgn ? 3'd2 : 3'd3, a, b, lat, nb);
    chk(req, "div LO quotient", lo_o, eq);
    chk(req, "div HI remainder", hi_o, er);
    chk("R9", "div latency", 32'(lat), 32'd34);
    chk("R9", "div busy cycles", 32'(nb), 32'd33);
    @(negedge clk);
    chk("R12", "done single pulse", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_moves();
    int lat, nb;
    logic [31:0] old_lo, old_hi;
    old_lo = lo_o;
    run_op(3'd4, 32'h1234_5678, 32'hFFFF_FFFF, lat, nb);
    chk("R10", "set HI value", hi_o, 32'h1234_5678);
    chk("R10", "set HI keeps LO", lo_o, old_lo);
    chk("R10", "set HI latency", 32'(lat), 32'd1);
    chk("R10", "set HI no busy", 32'(nb), 32'd0);
    old_hi = hi_o;
    run_op(3'd5, 32'hCAFE_F00D, 32'h0, lat, nb);
    chk("R10", "set LO value", lo_o, 32'hCAFE_F00D);
    chk("R10", "set LO keeps HI", hi_o, old_hi);
    chk("R10", "set LO latency", 32'(lat), 32'd1);
  endtask

  task automatic t_bad_ops();
    int lat, nb;
    logic [31:0] h, l;
    h = hi_o; l = lo_o;
    run_op(3'd6, 32'hAAAA_AAAA, 32'h5555_5555, lat, nb);
    chk("R2", "code 6 no done", 32'(lat), 32'd100);
    chk("R2", "code 6 HI kept", hi_o, h);
    chk("R2", "code 6 LO kept", lo_o, l);
    run_op(3'd7, 32'h1111_1111, 32'h2, lat, nb);
    chk("R2", "code 7 no done", 32'(lat), 32'd100);
    chk("R2", "code 7 HI kept", hi_o, h);
    chk("R2", "code 7 LO kept", lo_o, l);
  endtask

  task automatic t_intrude();
    int lat;
    @(negedge clk);
    op_i = 3'd3; a_i = 32'd100; b_i = 32'd7; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    op_i = 3'd4; a_i = 32'hDEAD_BEEF; start_i = 1'b1;
    @(negedge clk); lat++;
    start_i = 1'b0;
    chk("R11", "still busy after intrusion", {31'b0, busy_o}, 32'd1);
    while (!done_o && lat < 100) begin @(negedge clk); lat++; end
    chk("R11", "HI is remainder", hi_o, 32'd2);
    chk("R11", "LO is quotient", lo_o, 32'd14);
    chk("R11", "latency unchanged", 32'(lat), 32'd34);
    @(negedge clk);
    chk("R11", "no late done", {31'b0, done_o}, 32'd0);
    chk("R11", "HI not overwritten", hi_o, 32'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset HI", hi_o, 32'd0);
    chk("R1", "reset LO", lo_o, 32'd0);
    chk("R1", "reset busy/done", {30'b0, busy_o, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset busy/done", {30'b0, busy_o, done_o}, 32'd0);

    t_mul(1'b1, 32'd7, 32'd6);
    t_mul(1'b1, 32'hFFFF_FFFD, 32'd5);
    t_mul(1'b1, 32'h8000_0000, 32'h8000_0000);
    t_mul(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_mul(1'b0, 32'h8000_0000, 32'd2);

    t_div(1'b0, 32'd100, 32'd7, "R5");
    t_div(1'b0, 32'hFFFF_FFFF, 32'd16, "R5");
    t_div(1'b1, 32'hFFFF_FFF9, 32'd2, "R6");
    t_div(1'b1, 32'd7, 32'hFFFF_FFFE, "R6");
    t_div(1'b1, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R6");
    t_div(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R7");
    chk("R7", "min/-1 LO", lo_o, 32'h8000_0000);
    chk("R7", "min/-1 HI", hi_o, 32'd0);
    t_div(1'b1, 32'hFFFF_FFF0, 32'd0, "R8");
    t_mul(1'b0, 32'hFFFF_FFFF, 32'd3);
    t_div(1'b0, 32'd12345, 32'd0, "R8");

    t_moves();
    t_bad_ops();
    t_intrude();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule